// File: doc/BRIEF.md
# Two-to-Four-Phase Handshake Bridge

This block joins a producer that speaks a transition-signalling handshake to a consumer that speaks a level-signalling, return-to-zero handshake, and carries a data word across with the control. On the producer side every change of the request line, upward or downward, announces one new item. The bridge answers each item with one change of its own acknowledge line. On the consumer side each item becomes one complete level cycle, in this order: request up, acknowledge up, request down, acknowledge down.

Both sides are sampled in a single clock domain. The bridge keeps the previous producer request level in a flop and compares it with the current level to spot a new item. The word is latched into a holding register at that moment, and the register drives the consumer bus for the whole level cycle. The producer is released only once the consumer has gone all the way back to idle. If the producer changes its request again while a cycle is still open, a sticky error flag is set.

Top module: `hs_bridge_2to4`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `snk_req`, `src_ack` and `proto_err` are 0. The bridge is then idle, and its stored producer request level is 0.
- R2: A change of `src_req` in either direction, seen while idle, makes `snk_req` 1 at the next rising clock edge.
- R3: `snk_data` takes the value `src_data` held at the clock edge where the new item is detected. It then keeps that value until the next item is detected, which covers the whole level cycle.
- R4: `snk_req` stays 1 while `snk_ack` is 0. At the first clock edge where `snk_ack` is seen high, `snk_req` goes to 0.
- R5: `src_ack` changes level exactly once per item, at the clock edge where `snk_ack` is seen low after `snk_req` has dropped. It never changes while `snk_req` or `snk_ack` is 1.
- R6: Without a new change of `src_req`, `snk_req` stays 0 after a cycle completes.
- R7: A change of `src_req` seen while a level cycle is open sets `proto_err` at the next edge. It stays 1 until reset and does not start an extra cycle.
- R8: Changes of `src_data` that come with no `src_req` change leave `snk_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 1 | Producer request; each level change is one item |
| src_data | input | DATA_W | Producer data word, valid when `src_req` changes |
| src_ack | output | 1 | Producer acknowledge; changes level once per finished item |
| snk_req | output | 1 | Consumer request, return-to-zero |
| snk_data | output | DATA_W | Held data word for the consumer |
| snk_ack | input | 1 | Consumer acknowledge, return-to-zero |
| proto_err | output | 1 | Sticky flag: producer changed request during an open cycle |

## Verification
The assertions assume the consumer follows the level protocol. That means `snk_ack` rises only while `snk_req` is high and falls only after `snk_req` has dropped. The bench consumer raises and lowers its acknowledge only in those windows, with a swept delay of zero to three cycles. The bench producer changes its request only after it sees `src_ack` move, except in the single deliberate violation case, which checks R7.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    RTZ_IDLE    = 2'd0,
    RTZ_WAIT_HI = 2'd1,
    RTZ_WAIT_LO = 2'd2
  } rtz_state_t;
endpackage

// File: rtl/hsb_toggle_sense.sv
module hsb_toggle_sense (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic toggled
);
  logic lvl_seen;

  always_ff @(posedge clk) begin
    if (rst) lvl_seen <= 1'b0;
    else     lvl_seen <= lvl_in;
  end

  assign toggled = lvl_in ^ lvl_seen;

  // R2: a detected change means the held level differs from the input now
  assert_toggle_seen_R2: assert property (@(posedge clk) disable iff (rst)
    toggled |=> (lvl_seen == $past(lvl_in)));
endmodule

// File: rtl/hsb_word_hold.sv
module hsb_word_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] q_out
);
  always_ff @(posedge clk) begin
    if (rst)       q_out <= '0;
    else if (load) q_out <= d_in;
  end
endmodule

// File: rtl/hsb_rtz_seq.sv
module hsb_rtz_seq
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic snk_ack,
  output logic load,
  output logic busy,
  output logic snk_req,
  output logic src_ack,
  output logic proto_err
);
  rtz_state_t state;

  assign busy = (state != RTZ_IDLE);
  assign load = (state == RTZ_IDLE) && evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RTZ_IDLE;
      snk_req   <= 1'b0;
      src_ack   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (evt && busy) proto_err <= 1'b1;
      case (state)
        RTZ_IDLE: begin
          if (evt) begin
            snk_req <= 1'b1;
            state   <= RTZ_WAIT_HI;
          end
        end
        RTZ_WAIT_HI: begin
          if (snk_ack) begin
            snk_req <= 1'b0;
            state   <= RTZ_WAIT_LO;
          end
        end
        RTZ_WAIT_LO: begin
          if (!snk_ack) begin
            src_ack <= ~src_ack;
            state   <= RTZ_IDLE;
          end
        end
        default: begin
          snk_req <= 1'b0;
          state   <= RTZ_IDLE;
        end
      endcase
    end
  end

  // R4: request holds until the consumer answers
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (snk_req && !snk_ack) |=> snk_req);

  // R5: producer acknowledge moves only with the consumer side at rest
  assert_ack_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(src_ack) |-> (!snk_req && !snk_ack));

  // R7: error flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

// File: rtl/hs_bridge_2to4.sv
module hs_bridge_2to4 #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_req,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ack,
  output logic              snk_req,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ack,
  output logic              proto_err
);
  logic evt;
  logic load;
  logic busy;

  hsb_toggle_sense u_sense (
    .clk     (clk),
    .rst     (rst),
    .lvl_in  (src_req),
    .toggled (evt)
  );

  hsb_rtz_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .snk_ack   (snk_ack),
    .load      (load),
    .busy      (busy),
    .snk_req   (snk_req),
    .src_ack   (src_ack),
    .proto_err (proto_err)
  );

  hsb_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .d_in  (src_data),
    .q_out (snk_data)
  );

  // R3: consumer word frozen while a level cycle is open
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(snk_data));

  // R6: request rises only from an idle bridge
  assert_rise_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(snk_req) |-> $past(!busy));
endmodule

// File: tb/hs_bridge_2to4_test.sv
`timescale 1ns/1ps
module hs_bridge_2to4_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         src_req = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_ack;
  logic         snk_req;
  logic [W-1:0] snk_data;
  logic         snk_ack = 1'b0;
  logic         proto_err;

  int checks = 0;
  int errors = 0;
  logic exp_ack = 1'b0;

  always #10 clk = ~clk;

  hs_bridge_2to4 #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_data(src_data),
    .src_ack(src_ack), .snk_req(snk_req), .snk_data(snk_data),
    .snk_ack(snk_ack), .proto_err(proto_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic item(input logic [W-1:0] val, input int dly);
    src_data = val;
    src_req  = ~src_req;
    tick();
    chk("R2 snk_req rise", snk_req, 1);
    chk("R3 captured word", snk_data, val);
    src_data = ~val;
    for (int i = 0; i < dly; i++) begin
      tick();
      chk("R4 req held", snk_req, 1);
      chk("R8 data unchanged", snk_data, val);
      chk("R5 ack quiet", src_ack, exp_ack);
    end
    snk_ack = 1'b1;
    tick();
    chk("R4 req drop", snk_req, 0);
    chk("R3 data held in drop", snk_data, val);
    for (int i = 0; i < dly; i++) begin
      tick();
      chk("R5 ack quiet while snk_ack high", src_ack, exp_ack);
    end
    snk_ack = 1'b0;
    tick();
    exp_ack = ~exp_ack;
    chk("R5 ack toggled", src_ack, exp_ack);
    tick();
    chk("R6 no re-request", snk_req, 0);
    chk("R5 single toggle", src_ack, exp_ack);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset snk_req", snk_req, 0);
    chk("R1 reset src_ack", src_ack, 0);
    chk("R1 reset proto_err", proto_err, 0);
    tick();
    rst = 1'b0;
    tick();
    chk("R1 post-reset snk_req", snk_req, 0);
    // R8: data changes alone do nothing
    src_data = 4'hA;
    tick();
    chk("R8 idle data ignored", snk_data, 0);
    chk("R6 idle no request", snk_req, 0);
    // sweep all words, both toggle directions, four delays
    for (int d = 0; d < 4; d++)
      for (int v = 0; v < 16; v++)
        item(v[W-1:0], d);
    chk("R7 no error on clean traffic", proto_err, 0);
    // R7: producer violates by toggling mid-cycle
    src_data = 4'h5;
    src_req  = ~src_req;
    tick();
    src_data = 4'h9;
    src_req  = ~src_req;
    tick();
    chk("R7 err set", proto_err, 1);
    chk("R7 data not reloaded", snk_data, 5);
    snk_ack = 1'b1;
    tick();
    snk_ack = 1'b0;
    tick();
    exp_ack = ~exp_ack;
    chk("R7 cycle completes", src_ack, exp_ack);
    tick();
    chk("R7 no extra cycle", snk_req, 0);
    chk("R7 err sticky", proto_err, 1);
    // R1: reset clears everything
    rst = 1'b1;
    src_req = 1'b0;
    tick();
    rst = 1'b0;
    tick();
    chk("R1 reset clears err", proto_err, 0);
    chk("R1 reset clears ack", src_ack, 0);
    chk("R1 reset idle req", snk_req, 0);
    exp_ack = 1'b0;
    item(4'hF, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule